// File: doc/BRIEF.md
# Control Register Bank with Soft-Reset Handshake

This block holds the main control word of a display peripheral. Software reaches the word through three word addresses. A plain write replaces the writable fields. A set alias ORs the written ones into the word. A clear alias removes the written ones from the word. A fourth address is unmapped.

Two of the bits behave differently from ordinary storage:

- **Soft-reset bit.** Raising it starts a fixed-length reset sequence. While the bit is high, every functional field is held at its reset value. When the sequence ends, the hardware reports completion by raising the clock-gate bit. To bring the core back up, software clears the clock-gate bit and then clears the soft-reset bit.
- **Run bit.** When software clears it, the clear waits for the end of the frame in progress. The display engine marks that point with a one-cycle frame-done pulse. A loop bit chooses whether the run bit stays set across frames or drops after a single frame.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset the word reads 0xC000_0000, with soft-reset at bit 31 and clock-gate at bit 30 both set. The outputs are core_en=0, clk_gate=1, soft_rst=1 and run=0.
- R2: A write to word address 0 replaces all implemented fields: run at bit 0, loop at bit 1, cfg at bits 7:4, clock-gate at bit 30 and soft-reset at bit 31. Unimplemented bits always read 0.
- R3: A write to word address 1 sets only the bits written as 1. A write to word address 2 clears only the bits written as 1. All other bits keep their value.
- R4: When soft-reset is set while it was 0, soft_rst goes high after that write edge. clk_gate then goes high exactly RST_CYCLES (4) clock edges later.
- R5: While soft-reset is 1, the run, loop and cfg fields read 0, and writes to them are ignored.
- R6: Setting soft-reset while it is already 1 starts no new sequence. A clock-gate bit that software has cleared stays 0.
- R7: core_en is 1 only when soft-reset and clock-gate are both 0. The core is released by clearing clock-gate and then soft-reset.
- R8: A write that clears the run bit while it is 1 leaves run reading 1 until the edge that samples frame_done=1. Run drops to 0 after that edge.
- R9: With loop=0, run drops by itself at the first frame_done pulse. With loop=1 and no pending clear, frame_done leaves run set. frame_done has no effect while run is 0.
- R10: A write to word address 3 changes nothing, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address: 0 plain, 1 set alias, 2 clear alias |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| core_en | output | 1 | Core enabled |
| clk_gate | output | 1 | Clock-gate bit |
| soft_rst | output | 1 | Soft-reset bit |
| run | output | 1 | Run bit |

## Verification
All register fields change on the clock edge that samples the write. Read data follows the address within the same cycle, so every plain check samples one cycle after the write strobe is driven.

The two timed paths are checked cycle by cycle:
- The clock-gate rise is sampled after each of the four edges that follow the reset request, and must appear only after the fourth.
- The deferred run-clear is sampled across several idle cycles and then after the frame_done edge.

The driver pushes each expectation at the point where it is due. The monitor compares it a fixed 1 ns later, well clear of the next edge.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int DATA_W    = 32;
  localparam int RUN_BIT   = 0;
  localparam int LOOP_BIT  = 1;
  localparam int CFG_LSB   = 4;
  localparam int CGATE_BIT = 30;
  localparam int SRST_BIT  = 31;
  localparam int OFS_PLAIN = 0;
  localparam int OFS_SET   = 1;
  localparam int OFS_CLR   = 2;

  typedef enum logic [1:0] {WK_NONE, WK_PLAIN, WK_SET, WK_CLR} wr_kind_e;

  // Value the word takes for a given write kind
  function automatic logic [DATA_W-1:0] merge_write(wr_kind_e k,
                                                    logic [DATA_W-1:0] cur,
                                                    logic [DATA_W-1:0] wd);
    case (k)
      WK_PLAIN: merge_write = wd;
      WK_SET:   merge_write = cur | wd;
      WK_CLR:   merge_write = cur & ~wd;
      default:  merge_write = cur;
    endcase
  endfunction
endpackage

// File: rtl/ctrl_alias_dec.sv
module ctrl_alias_dec
  import ctrl_reg_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_kind_e          kind,
  output logic              hit,
  output logic              rd_ok
);
  always_comb begin
    kind  = WK_NONE;
    rd_ok = 1'b1;
    case (addr)
      ADDR_W'(OFS_PLAIN): kind = we ? WK_PLAIN : WK_NONE;
      ADDR_W'(OFS_SET):   kind = we ? WK_SET   : WK_NONE;
      ADDR_W'(OFS_CLR):   kind = we ? WK_CLR   : WK_NONE;
      default:            rd_ok = 1'b0;
    endcase
    hit = (kind != WK_NONE);
  end
endmodule

// File: rtl/ctrl_srst_seq.sv
module ctrl_srst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic srst_nxt,
  input  logic req_cgate,
  output logic srst_q,
  output logic cgate_q,
  output logic start,
  output logic done
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign start = srst_nxt & ~srst_q;
  assign done  = (cnt_q == CNT_W'(1)) & srst_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b1;
      cgate_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      srst_q <= srst_nxt;
      if (start)             cnt_q <= CNT_W'(RST_CYCLES);
      else if (!srst_nxt)    cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      if (done)              cgate_q <= 1'b1;
      else if (wr_hit)       cgate_q <= req_cgate;
    end
  end
endmodule

// File: rtl/ctrl_run_ctl.sv
module ctrl_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic wr_hit,
  input  logic req_run,
  input  logic req_loop,
  input  logic frame_done,
  output logic run_q,
  output logic loop_q,
  output logic pend_q
);
  logic loop_nxt, clr_req, end_now;

  assign loop_nxt = wr_hit ? req_loop : loop_q;
  assign clr_req  = wr_hit & ~req_run & run_q;
  assign end_now  = run_q & frame_done & (pend_q | clr_req | ~loop_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      loop_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (hold) begin
      run_q  <= 1'b0;
      loop_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      loop_q <= loop_nxt;
      if (!run_q) begin
        run_q  <= wr_hit & req_run;
        pend_q <= 1'b0;
      end else if (end_now) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (clr_req) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CFG_W      = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_done,
  output logic              core_en,
  output logic              clk_gate,
  output logic              soft_rst,
  output logic              run
);
  wr_kind_e          kind;
  logic              wr_hit, rd_ok;
  logic [DATA_W-1:0] cur_word, req_word;
  logic [CFG_W-1:0]  cfg_q;
  logic              loop_q, pend_q, srst_nxt;
  logic              seq_start, seq_done;

  ctrl_alias_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .kind(kind), .hit(wr_hit), .rd_ok(rd_ok)
  );

  always_comb begin
    cur_word = '0;
    cur_word[RUN_BIT]               = run;
    cur_word[LOOP_BIT]              = loop_q;
    cur_word[CFG_LSB +: CFG_W]      = cfg_q;
    cur_word[CGATE_BIT]             = clk_gate;
    cur_word[SRST_BIT]              = soft_rst;
  end

  assign req_word  = merge_write(kind, cur_word, bus_wdata);
  assign srst_nxt  = wr_hit ? req_word[SRST_BIT] : soft_rst;
  assign bus_rdata = rd_ok ? cur_word : '0;
  assign core_en   = ~soft_rst & ~clk_gate;

  ctrl_srst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .srst_nxt(srst_nxt),
    .req_cgate(req_word[CGATE_BIT]), .srst_q(soft_rst), .cgate_q(clk_gate),
    .start(seq_start), .done(seq_done)
  );

  ctrl_run_ctl u_run (
    .clk(clk), .rst_n(rst_n), .hold(srst_nxt), .wr_hit(wr_hit),
    .req_run(req_word[RUN_BIT]), .req_loop(req_word[LOOP_BIT]),
    .frame_done(frame_done), .run_q(run), .loop_q(loop_q), .pend_q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (srst_nxt) cfg_q <= '0;
    else if (wr_hit)   cfg_q <= req_word[CFG_LSB +: CFG_W];
  end
endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk #(
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 4,
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              run,
  input logic              soft_rst,
  input logic              clk_gate,
  input logic [DATA_W-1:0] rdata,
  input logic              seq_start,
  input logic              seq_done
);
  logic [15:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_start <= '0;
    else if (seq_start)          since_start <= 16'd1;
    else if (since_start != '1)  since_start <= since_start + 1'b1;
  end

  AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (since_start == 16'(RST_CYCLES)));                       // R4
  AST_GATE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> clk_gate);                                               // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !soft_rst);                                             // R6
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (rdata[4+CFG_W-1:0] == '0));                             // R5
  AST_RUN_DROP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(frame_done) || soft_rst));                      // R8
  AST_RUN_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !soft_rst);                                            // R5
endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(
  .DATA_W(ctrl_reg_pkg::DATA_W), .CFG_W(CFG_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .run(run),
  .soft_rst(soft_rst), .clk_gate(clk_gate), .rdata(bus_rdata),
  .seq_start(seq_start), .seq_done(seq_done)
);

// File: tb/tb_ctrl_reg_bank.sv
module tb_ctrl_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0;
  logic        core_en, clk_gate, soft_rst, run;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [3:0]  outs;   // {core_en, clk_gate, soft_rst, run}
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  ctrl_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .core_en(core_en), .clk_gate(clk_gate), .soft_rst(soft_rst), .run(run)
  );

  // Monitor: compares each expectation shortly after it is pushed
  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      begin
        exp_t e;
        logic [3:0] act;
        e = q.pop_front();
        act = {core_en, clk_gate, soft_rst, run};
        n_vec++;
        if (bus_rdata !== e.rd || act !== e.outs) begin
          n_bad++;
          $display("FAIL %s: rdata=%h outs=%b expected rdata=%h outs=%b",
                   e.tag, bus_rdata, act, e.rd, e.outs);
        end
      end
    end
  end

  task automatic expect_at(string tag, logic [1:0] a, logic [31:0] rd,
                           logic [3:0] o);
    exp_t e;
    bus_addr = a;
    e.tag = tag; e.rd = rd; e.outs = o;
    q.push_back(e);
    #3;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    expect_at("R1 reset state", 2'd0, 32'hC000_0000, 4'b0110);

    // R6: request reset while already in reset
    wr(2'd1, 32'h8000_0000);
    expect_at("R6 set while in reset", 2'd0, 32'hC000_0000, 4'b0110);
    wr(2'd2, 32'h4000_0000);
    expect_at("R6 gate cleared", 2'd0, 32'h8000_0000, 4'b0010);
    idle(6);
    expect_at("R6 no new sequence", 2'd0, 32'h8000_0000, 4'b0010);

    // R5: field writes ignored in reset
    wr(2'd1, 32'h0000_00F3);
    expect_at("R5 writes ignored", 2'd0, 32'h8000_0000, 4'b0010);

    // R7: release
    wr(2'd2, 32'h8000_0000);
    expect_at("R7 core released", 2'd0, 32'h0000_0000, 4'b1000);

    // R2: plain write
    wr(2'd0, 32'h0000_00A2);
    expect_at("R2 plain write", 2'd0, 32'h0000_00A2, 4'b1000);
    wr(2'd0, 32'h0000_FFA2);
    expect_at("R2 unimplemented bits", 2'd0, 32'h0000_00A2, 4'b1000);

    // R3: set and clear aliases
    wr(2'd1, 32'h0000_0050);
    expect_at("R3 set alias", 2'd0, 32'h0000_00F2, 4'b1000);
    wr(2'd2, 32'h0000_0032);
    expect_at("R3 clear alias", 2'd0, 32'h0000_00C0, 4'b1000);

    // R9: single frame
    wr(2'd1, 32'h0000_0001);
    expect_at("R9 run set", 2'd0, 32'h0000_00C1, 4'b1001);
    pulse_frame();
    expect_at("R9 one-shot ends", 2'd0, 32'h0000_00C0, 4'b1000);

    // R9: looping
    wr(2'd1, 32'h0000_0003);
    expect_at("R9 loop run", 2'd0, 32'h0000_00C3, 4'b1001);
    pulse_frame();
    expect_at("R9 loop persists", 2'd0, 32'h0000_00C3, 4'b1001);

    // R8: deferred clear
    wr(2'd2, 32'h0000_0001);
    expect_at("R8 clear deferred", 2'd0, 32'h0000_00C3, 4'b1001);
    idle(3);
    expect_at("R8 still running", 2'd0, 32'h0000_00C3, 4'b1001);
    pulse_frame();
    expect_at("R8 clear at frame end", 2'd0, 32'h0000_00C2, 4'b1000);
    pulse_frame();
    expect_at("R9 frame while idle", 2'd0, 32'h0000_00C2, 4'b1000);

    // R10: unmapped address
    wr(2'd3, 32'hFFFF_FFFF);
    expect_at("R10 write ignored", 2'd0, 32'h0000_00C2, 4'b1000);
    expect_at("R10 read zero", 2'd3, 32'h0000_0000, 4'b1000);

    // R4: full reset sequence timing
    wr(2'd1, 32'h0000_0001);
    expect_at("R4 run before reset", 2'd0, 32'h0000_00C3, 4'b1001);
    wr(2'd1, 32'h8000_0000);
    expect_at("R4 edge 0", 2'd0, 32'h8000_0000, 4'b0010);
    idle(1);
    expect_at("R4 edge 1", 2'd0, 32'h8000_0000, 4'b0010);
    idle(1);
    expect_at("R4 edge 2", 2'd0, 32'h8000_0000, 4'b0010);
    idle(1);
    expect_at("R4 edge 3", 2'd0, 32'h8000_0000, 4'b0010);
    idle(1);
    expect_at("R4 edge 4 gate set", 2'd0, 32'hC000_0000, 4'b0110);

    // R7: release order
    wr(2'd2, 32'h4000_0000);
    expect_at("R7 gate cleared, still held", 2'd0, 32'h8000_0000, 4'b0010);
    wr(2'd2, 32'h8000_0000);
    expect_at("R7 released again", 2'd0, 32'h0000_0000, 4'b1000);

    wait (q.size() == 0);
    #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule